// File: doc/BRIEF.md
# Banked GPIO Controller with Shared Interrupt

This block gives software a set of general-purpose pins grouped into banks of up to 32 pins each. Each bank has a data word, a per-pin direction control, an open-drain option and per-pin interrupt configuration. Software reaches all of it through a single-cycle register port: writes take effect on the clock edge, and reads return data combinationally in the same cycle.

Pin inputs are brought into the clock domain through a two-stage synchroniser. Per-pin logic then looks for a rising edge, a falling edge, either edge or a high level. An event sets a sticky status bit, and software clears that bit by writing a one to it. Each bank ANDs its status with its interrupt mask. The requests of all banks are ORed onto one interrupt line. A bank can be narrower than 32 pins. Bits above its width are inert.

Top module: `gpio_ctrl`

## Requirements
- R1: Bank n owns the byte window 0x20*n to 0x20*n+0x1F. Its registers sit at these offsets: 0x00 open-drain enable, 0x04 data, 0x08 direction, 0x0C edge select, 0x10 both-edge select, 0x14 interrupt mask, 0x18 level select, 0x1C status. A read in a window with no bank returns zero.
- R2: A direction bit of 1 makes the pin an input and a direction bit of 0 makes it an output. Out of reset every pin is an input (direction reads all ones over the bank width) and pin_oe is low. An output pin drives pin_out from its data bit. A read at offset 0x04 returns the synchronised pin value for input pins and the data bit for output pins.
- R3: In a bank of width W, bits at W and above read as zero, are never driven (pin_oe low) and never set status.
- R4: With the level bit and the both-edge bit at 0, an edge select bit of 1 makes a rising edge set status, and 0 makes a falling edge set it. A status bit changes only when an event occurs or software clears it.
- R5: With the level bit at 0 and the both-edge bit at 1, both rising and falling edges set status.
- R6: With the level bit at 1, status is set on every cycle that the synchronised input is high. A clear therefore only sticks once the input is low.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear wins.
- R8: irq is the OR over all banks of status AND mask. Mask resets to zero.
- R9: On an output pin with its open-drain bit set, data 0 drives low (pin_oe high, pin_out low) and data 1 releases the pin (pin_oe low).
- R10: A pin change applied before clock edge k sets status at edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NUM_BANKS*32 | Pin inputs, bank n at bits 32n+31:32n |
| pin_out | output | NUM_BANKS*32 | Pin output values |
| pin_oe | output | NUM_BANKS*32 | Pin output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
A corrupted configuration or status register shows up at bus_rdata as soon as that register is read. A bad status bit that is unmasked also shows up on irq in the same cycle. An error in the synchroniser or edge-detector depth moves the status set by one or more edges, so the bench samples status both one edge before and at the expected edge after each pin change. Stuck or wrongly cleared status is exposed by reading status directly after a clear, with the pin held either active or inactive.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int MAX_PINS  = 32;
  localparam int BANK_SPAN = 32;  // bytes per bank window

  typedef logic [MAX_PINS-1:0] word_t;

  typedef enum logic [2:0] {
    REG_ODRAIN = 3'd0,
    REG_DATA   = 3'd1,
    REG_DIR    = 3'd2,
    REG_EDGE   = 3'd3,
    REG_BOTH   = 3'd4,
    REG_MASK   = 3'd5,
    REG_LEVEL  = 3'd6,
    REG_STAT   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_n [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_n[s] = d;
      end else begin : g_next
        assign stg_n[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_n[s];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] both,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_n;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  assign prev_n = smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_n;
  end

  assign rise = smp & ~prev_q;
  assign fall = ~smp & prev_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      always_comb begin
        if (lvl[i])           evt[i] = smp[i];
        else if (both[i])     evt[i] = rise[i] | fall[i];
        else if (rise_sel[i]) evt[i] = rise[i];
        else                  evt[i] = fall[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  reg_sel_e sel,
  input  word_t    wdata,
  output word_t    rdata,
  input  word_t    pin_in,
  output word_t    pin_out,
  output word_t    pin_oe,
  output logic     req
);
  localparam word_t WMASK = word_t'(32'hFFFF_FFFF >> (MAX_PINS - WIDTH));

  word_t od_q, data_q, dir_q, edge_q, both_q, mask_q, lvl_q, stat_q;
  word_t od_n, data_n, dir_n, edge_n, both_n, mask_n, lvl_n, stat_n;
  word_t pin_s, evt_raw, evt, clr;
  word_t wmasked;

  gpio_sync #(.W(MAX_PINS), .STAGES(2)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_in & WMASK),
    .q (pin_s)
  );

  gpio_evt #(.W(MAX_PINS)) u_evt (
    .clk (clk),
    .rst_n (rst_n),
    .smp (pin_s),
    .lvl (lvl_q),
    .both (both_q),
    .rise_sel (edge_q),
    .evt (evt_raw)
  );

  assign evt     = evt_raw & WMASK;
  assign wmasked = wdata & WMASK;
  assign clr     = (wr_en && sel == REG_STAT) ? wmasked : '0;

  // next state
  always_comb begin
    od_n   = od_q;
    data_n = data_q;
    dir_n  = dir_q;
    edge_n = edge_q;
    both_n = both_q;
    mask_n = mask_q;
    lvl_n  = lvl_q;
    if (wr_en) begin
      case (sel)
        REG_ODRAIN: od_n   = wmasked;
        REG_DATA:   data_n = wmasked;
        REG_DIR:    dir_n  = wmasked;
        REG_EDGE:   edge_n = wmasked;
        REG_BOTH:   both_n = wmasked;
        REG_MASK:   mask_n = wmasked;
        REG_LEVEL:  lvl_n  = wmasked;
        default:    ;
      endcase
    end
    stat_n = ((stat_q & ~clr) | evt) & WMASK;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q   <= '0;
      data_q <= '0;
      dir_q  <= WMASK;
      edge_q <= '0;
      both_q <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
      stat_q <= '0;
    end else begin
      od_q   <= od_n;
      data_q <= data_n;
      dir_q  <= dir_n;
      edge_q <= edge_n;
      both_q <= both_n;
      mask_q <= mask_n;
      lvl_q  <= lvl_n;
      stat_q <= stat_n;
    end
  end

  always_comb begin
    case (sel)
      REG_ODRAIN: rdata = od_q;
      REG_DATA:   rdata = (dir_q & pin_s) | (~dir_q & data_q);
      REG_DIR:    rdata = dir_q;
      REG_EDGE:   rdata = edge_q;
      REG_BOTH:   rdata = both_q;
      REG_MASK:   rdata = mask_q;
      REG_LEVEL:  rdata = lvl_q;
      default:    rdata = stat_q;
    endcase
  end

  assign pin_out = data_q & ~od_q & WMASK;
  assign pin_oe  = ~dir_q & (~od_q | ~data_q) & WMASK;
  assign req     = |(stat_q & mask_q);

  // status bits rise only from a detected event
  p_set_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(evt)) == '0);

  // a cleared bit with no event that cycle reads zero next cycle
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr & ~evt) != '0 |=> (stat_q & $past(clr & ~evt)) == '0);

  // active level keeps status set
  p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q & pin_s) != '0 |=> (stat_q & $past(lvl_q & pin_s)) == $past(lvl_q & pin_s));

  // open-drain output with data 1 never drives
  p_od_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & od_q & data_q) == '0);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int                     NUM_BANKS = 2,
  parameter int                     ADDR_W    = 8,
  parameter logic [NUM_BANKS*6-1:0] WIDTHS    = {6'd20, 6'd32}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_BANKS*32-1:0] pin_in,
  output logic [NUM_BANKS*32-1:0] pin_out,
  output logic [NUM_BANKS*32-1:0] pin_oe,
  output logic                    irq
);
  localparam int OFS_W  = $clog2(BANK_SPAN);
  localparam int BSEL_W = ADDR_W - OFS_W;

  logic rst_meta_q, rst_sync_q;
  logic [1:0] addr_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [BSEL_W-1:0] bank_idx;
  reg_sel_e          sel;
  word_t             bank_rd  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_req;

  assign bank_idx    = bus_addr[ADDR_W-1:OFS_W];
  assign sel         = reg_sel_e'(bus_addr[OFS_W-1:2]);
  assign addr_unused = bus_addr[1:0];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (bank_idx == BSEL_W'(b));
      gpio_bank #(.WIDTH(int'(WIDTHS[b*6 +: 6]))) u_bank (
        .clk     (clk),
        .rst_n   (rst_sync_q),
        .wr_en   (bus_wr && hit),
        .sel     (sel),
        .wdata   (bus_wdata),
        .rdata   (bank_rd[b]),
        .pin_in  (pin_in[b*32 +: 32]),
        .pin_out (pin_out[b*32 +: 32]),
        .pin_oe  (pin_oe[b*32 +: 32]),
        .req     (bank_req[b])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BSEL_W'(b)) bus_rdata = bank_rd[b];
    end
  end

  assign irq = |bank_req;
endmodule

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NB*32-1:0] pin_in, pin_out, pin_oe;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_ctrl #(.NUM_BANKS(NB), .ADDR_W(8), .WIDTHS({6'd20, 6'd32})) u_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {addr, wdata, expected readback}
  localparam logic [71:0] VEC [8] = '{
    {8'h00, 32'hAAAA5555, 32'hAAAA5555},
    {8'h08, 32'h0F0F0F0F, 32'h0F0F0F0F},
    {8'h0C, 32'h12345678, 32'h12345678},
    {8'h10, 32'h87654321, 32'h87654321},
    {8'h14, 32'hDEADBEEF, 32'hDEADBEEF},
    {8'h20, 32'hFFFFFFFF, 32'h000FFFFF},
    {8'h34, 32'h12345678, 32'h00045678},
    {8'h28, 32'h00000000, 32'h00000000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    pin_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    edges(3);
    rst_n = 1'b1;
    edges(4);
  endtask

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // reset state
    chk("R2 oe at reset", pin_oe[31:0], 32'h0);
    chk("R2 oe at reset b1", pin_oe[63:32], 32'h0);
    rd(8'h08, v); chk("R2 dir reset", v, 32'hFFFFFFFF);
    rd(8'h28, v); chk("R3 dir reset b1", v, 32'h000FFFFF);
    rd(8'h14, v); chk("R8 mask reset", v, 32'h0);
    chk("R8 irq reset", {31'h0, irq}, 32'h0);

    // register map table (R1, R3)
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk("R1 regmap", v, VEC[i][31:0]);
    end
    rd(8'h40, v); chk("R1 empty window", v, 32'h0);

    // R2 direction and data
    do_reset();
    wr(8'h08, 32'hFFFF0000);
    wr(8'h04, 32'h0000A5A5);
    chk("R2 pin_out", pin_out[31:0], 32'h0000A5A5);
    chk("R2 pin_oe", pin_oe[31:0], 32'h0000FFFF);
    pin_in[31:0] = 32'h12340000;
    edges(3);
    rd(8'h04, v); chk("R2 data read mix", v, 32'h1234A5A5);

    // R3 width limit on bank 1
    do_reset();
    wr(8'h30, 32'hFFFFFFFF);
    wr(8'h28, 32'h00000000);
    chk("R3 oe above width", pin_oe[63:32], 32'h000FFFFF);
    pin_in[63:32] = 32'hFFFFFFFF;
    edges(3);
    rd(8'h3C, v); chk("R3 status above width", v, 32'h000FFFFF);

    // R4 / R10 edge select
    do_reset();
    wr(8'h0C, 32'h00000001);
    pin_in[1:0] = 2'b11;
    edges(2);
    rd(8'h1C, v); chk("R10 not yet set", v, 32'h0);
    edges(1);
    rd(8'h1C, v); chk("R4 rising only", v, 32'h1);
    pin_in[1:0] = 2'b00;
    edges(3);
    rd(8'h1C, v); chk("R4 falling added", v, 32'h3);

    // R7 clear
    wr(8'h1C, 32'h00000001);
    rd(8'h1C, v); chk("R7 w1c", v, 32'h2);
    wr(8'h1C, 32'h00000000);
    rd(8'h1C, v); chk("R7 write zero keeps", v, 32'h2);

    // R8 interrupt aggregation
    chk("R8 masked", {31'h0, irq}, 32'h0);
    wr(8'h14, 32'h00000002);
    chk("R8 unmasked", {31'h0, irq}, 32'h1);
    wr(8'h1C, 32'h00000002);
    chk("R8 cleared", {31'h0, irq}, 32'h0);
    wr(8'h34, 32'h00000001);
    wr(8'h30, 32'h00000001);
    pin_in[32] = 1'b1;
    edges(3);
    chk("R8 bank1 irq", {31'h0, irq}, 32'h1);

    // R5 both edges
    do_reset();
    wr(8'h10, 32'h00000010);
    pin_in[4] = 1'b1;
    edges(3);
    rd(8'h1C, v); chk("R5 rise", v, 32'h10);
    wr(8'h1C, 32'h10);
    pin_in[4] = 1'b0;
    edges(3);
    rd(8'h1C, v); chk("R5 fall", v, 32'h10);

    // R6 level
    do_reset();
    wr(8'h18, 32'h00000100);
    pin_in[8] = 1'b1;
    edges(3);
    rd(8'h1C, v); chk("R6 level set", v, 32'h100);
    wr(8'h1C, 32'h100);
    rd(8'h1C, v); chk("R6 clear while active", v, 32'h100);
    pin_in[8] = 1'b0;
    edges(3);
    wr(8'h1C, 32'h100);
    rd(8'h1C, v); chk("R6 clear when low", v, 32'h0);

    // R9 open drain
    do_reset();
    wr(8'h08, 32'hFFFFFFFB);
    wr(8'h00, 32'h00000004);
    wr(8'h04, 32'h00000000);
    chk("R9 drive low oe", pin_oe[31:0], 32'h4);
    chk("R9 drive low out", pin_out[31:0], 32'h0);
    wr(8'h04, 32'h00000004);
    chk("R9 release", pin_oe[31:0], 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule